// File: doc/BRIEF.md
# Tagged Many-to-One Message Merger

This block collects messages from several independent producers and funnels them onto one output channel. Every producer owns a private queue. A producer pushes a word whenever its ready line is high. On the output side, one non-empty queue at a time is chosen, and its oldest word is presented together with the number of the producer that wrote it. The consumer can then tell the sources apart without any extra sideband.

The choice between queues rotates so that every producer is served in turn. A word leaves its queue only when the consumer accepts it. While the consumer stalls, both the presented word and its tag stay frozen until acceptance.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block starts working two clock edges after `rst_n` rises.

Top module: `tag_merge`

## Requirements
- R1: While reset is applied, and after it is released, all queues are empty, `out_valid` is low and every `in_ready` bit is high.
- R2: `in_ready[i]` is high exactly when queue i holds fewer than DEPTH words. A write offered while `in_ready[i]` is low is dropped and never appears at the output.
- R3: `out_valid` is high exactly when at least one queue holds a word.
- R4: `out_data` is the oldest word of the chosen queue, and `out_id` is that queue's index (the bits of `out_id` are the binary producer number). Words from a single producer leave in the order they were written.
- R5: A queue loses its head word only in a cycle where `out_valid` and `out_ready` are both high. Exactly one word leaves, from the queue named by `out_id`.
- R6: Selection is round robin. After a word from producer i is accepted, the search for the next word starts at producer i+1 and wraps from NSRC-1 to 0. Before the first acceptance the search starts at producer 0.
- R7: While `out_valid` is high and `out_ready` is low, `out_id` and `out_data` hold their values on the next cycle, even if another queue becomes non-empty.
- R8: A write and a removal on the same queue in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NSRC | Per-producer write request |
| in_data | input | NSRC*DW | Per-producer write word, packed by producer index |
| in_ready | output | NSRC | Per-producer queue not full |
| out_valid | output | 1 | A tagged word is presented |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_id | output | IDW | Producer index of the presented word |
| out_data | output | DW | Presented word |

## Verification
The assertions assume the following about the inputs:
- A producer writes only on a cycle where its own ready bit is high, or else accepts that the write is dropped.
- The consumer may lower `out_ready` at any time and for any number of cycles.

The stimulus respects this as follows:
- It drives every input half a cycle away from the active edge.
- It deliberately offers writes to full queues, to show that they are dropped.
- It mixes long full stalls with random backpressure, so the hold rule and the rotation order are both exercised against a reference model of the queues.

// File: rtl/tm_pkg.sv
package tm_pkg;
  function automatic int wrap_inc(input int idx, input int n);
    return (idx >= n - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/tm_rst_sync.sv
module tm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/tm_queue.sv
module tm_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  // R2: a full queue with no removal stays full
  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full);
  // R5: removal from an empty queue never happens
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !push |=> empty);
  // R8: push and pop together keep the occupancy
  a_r8_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && pop && !empty) |=> $stable(cnt_q));
endmodule

// File: rtl/tm_rr_pick.sv
module tm_rr_pick #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic           take,
  output logic           gnt_vld,
  output logic [IDW-1:0] gnt_id
);
  import tm_pkg::*;

  logic [IDW-1:0] ptr_q, ptr_d, hold_q, hold_d, scan_id;
  logic           lock_q, lock_d, found;

  always_comb begin
    found   = 1'b0;
    scan_id = ptr_q;
    for (int k = 0; k < N; k++) begin
      int t;
      t = int'(ptr_q) + k;
      if (t >= N) t = t - N;
      if (!found && req[t]) begin
        found   = 1'b1;
        scan_id = IDW'(t);
      end
    end
  end

  assign gnt_vld = |req;
  assign gnt_id  = lock_q ? hold_q : scan_id;

  always_comb begin
    ptr_d  = ptr_q;
    hold_d = hold_q;
    lock_d = gnt_vld && !take;
    if (gnt_vld) hold_d = gnt_id;
    if (gnt_vld && take) ptr_d = IDW'(wrap_inc(int'(gnt_id), N));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      hold_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      hold_q <= hold_d;
      lock_q <= lock_d;
    end
  end

  // R4: the granted index always names a requesting queue
  a_r4_grant_is_requester: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_id]);
  // R7: a stalled grant stays on the same index
  a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld && !take |=> gnt_vld && $stable(gnt_id));
endmodule

// File: rtl/tag_merge.sv
module tag_merge #(
  parameter int NSRC  = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          in_valid,
  input  logic [NSRC-1:0][DW-1:0]  in_data,
  output logic [NSRC-1:0]          in_ready,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [IDW-1:0]           out_id,
  output logic [DW-1:0]            out_data
);
  logic                    rst_i;
  logic [NSRC-1:0]         nonempty, full_v, pop_v;
  logic [NSRC-1:0][DW-1:0] heads;

  tm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic emp;
    tm_queue #(.DW(DW), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_i),
      .push(in_valid[g]), .wdata(in_data[g]),
      .pop(pop_v[g]), .rdata(heads[g]),
      .empty(emp), .full(full_v[g])
    );
    assign nonempty[g] = !emp;
    assign in_ready[g] = !full_v[g];
    assign pop_v[g]    = out_valid && out_ready && (out_id == IDW'(g));
  end

  tm_rr_pick #(.N(NSRC), .IDW(IDW)) u_arb (
    .clk(clk), .rst_n(rst_i), .req(nonempty), .take(out_ready),
    .gnt_vld(out_valid), .gnt_id(out_id)
  );

  assign out_data = heads[out_id];

  // R7: stalled output word is frozen
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_data));
  // R5: at most one queue is drained per cycle, and only on acceptance
  a_r5_single_pop: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(pop_v));
  a_r5_pop_needs_ack: assert property (@(posedge clk) disable iff (!rst_i)
    (|pop_v) |-> out_valid && out_ready);
endmodule

// File: tb/tag_merge_bench.sv
module tag_merge_bench;
  localparam int NSRC = 4, DW = 8, DEPTH = 4, IDW = 2;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [NSRC-1:0]         in_valid;
  logic [NSRC-1:0][DW-1:0] in_data;
  logic [NSRC-1:0]         in_ready;
  logic                    out_valid, out_ready;
  logic [IDW-1:0]          out_id;
  logic [DW-1:0]           out_data;

  int total = 0, bad = 0;
  logic [DW-1:0] sbq [NSRC][$];
  int  ptr = 0;
  bit  held = 0;
  int  prev_id = 0;
  logic [DW-1:0] prev_data = '0;

  always #5 clk = ~clk;

  tag_merge #(.NSRC(NSRC), .DW(DW), .DEPTH(DEPTH)) u_tag_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_data(out_data));

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int exp_id();
    if (held) return prev_id;
    for (int k = 0; k < NSRC; k++) begin
      int t = (ptr + k) % NSRC;
      if (sbq[t].size() > 0) return t;
    end
    return -1;
  endfunction

  // driver + monitor, one cycle per call
  task automatic run(input int cycles, input int vmask, input int vpct, input int rpct);
    for (int c = 0; c < cycles; c++) begin
      int e;
      bit any, ack;
      logic [NSRC-1:0] acc;
      @(negedge clk);
      any = 0;
      for (int i = 0; i < NSRC; i++) begin
        if (sbq[i].size() > 0) any = 1;
        check("R2 in_ready", int'(in_ready[i]), int'(sbq[i].size() < DEPTH));
      end
      check("R3 out_valid", int'(out_valid), int'(any));
      if (any) begin
        e = exp_id();
        check("R6 out_id", int'(out_id), e);
        check("R4 out_data", int'(out_data), int'(sbq[e][0]));
        if (held) begin
          check("R7 held id", int'(out_id), prev_id);
          check("R7 held data", int'(out_data), int'(prev_data));
        end
      end
      for (int i = 0; i < NSRC; i++) begin
        in_valid[i] = vmask[i] && (($urandom % 100) < vpct);
        in_data[i]  = DW'($urandom);
      end
      out_ready = ($urandom % 100) < rpct;
      acc = in_valid & in_ready;
      ack = out_valid && out_ready;
      prev_id = int'(out_id);
      prev_data = out_data;
      @(posedge clk);
      if (ack) begin
        void'(sbq[prev_id].pop_front()); // R5 / R8 when also pushed
        ptr = (prev_id + 1) % NSRC;
      end
      held = out_valid && !out_ready;
      for (int i = 0; i < NSRC; i++)
        if (acc[i]) sbq[i].push_back(in_data[i]);
    end
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = '0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset ready", int'(in_ready), (1 << NSRC) - 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 post-reset valid", int'(out_valid), 0);
    check("R1 post-reset ready", int'(in_ready), (1 << NSRC) - 1);
    run(20, 4'b0001, 100, 100);
    run(40, 4'b1111, 100, 0);    // fill to full, writes to full queues dropped (R2)
    run(40, 4'b0000, 0, 100);    // drain in rotation (R6)
    run(400, 4'b1111, 60, 50);   // mixed traffic, same-cycle push/pop (R8)
    run(200, 4'b1010, 90, 30);   // heavy stalls (R7)
    run(50, 4'b0000, 0, 100);
    check("R3 drained", int'(out_valid), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule